// File: doc/BRIEF.md
# Table-Free Residue Generator for Moduli Just Below a Power of Two

This block turns a wide unsigned binary word into its residue modulo M = 2^N − K. It is purely combinational and uses no lookup tables. The input of 4N bits is cut into four N-bit fields. Because 2^N is congruent to K modulo M, the field weights 2^{3N}, 2^{2N} and 2^N can be replaced by small constants: K^3 and K^2, each pre-reduced modulo M, and K itself.

The block adds the four weighted fields. It then folds the sum back towards N bits in further passes. Each pass splits the running sum at bit N and multiplies the upper part by a constant. A last adder subtracts M at most once, which brings the result into 0..M−1. The block is meant as the entry stage of a residue-number datapath, and one instance is placed for each channel.

The parameters are N and K. K must be at least 3, and P = ceil(log2 K) must not exceed N/2. When N ≥ 2P+1 the block leaves out one folding pass, together with its multiplier and adder. A generate branch selects this variant from the parameters alone.

Top module: `resconv_mk`

## Requirements
- R1: For every 4N-bit input X, the output equals X mod (2^N − K).
- R2: The output is always strictly less than the modulus 2^N − K.
- R3: The first weighted sum (pre-reduced K^3, pre-reduced K^2, K and 1 applied to the fields, from the most significant field down) fits in 2N+2 bits.
- R4: The second pass applies the pre-reduced K^2 to bits 2N+1..2N of the first sum, applies K to bits 2N−1..N, and adds bits N−1..0. Its result fits in N+P+1 bits and keeps the residue unchanged.
- R5: When N < 2P+1, a third pass applies K to bits N+P..N and adds bits N−1..0. Its result fits in N+3 bits and keeps the residue unchanged.
- R6: The raw sum entering the final modular adder is below twice the modulus, so one conditional subtraction of the modulus is enough.
- R7: An all-zero input and any exact multiple of the modulus give 0. An all-ones input gives (2^{4N} − 1) mod (2^N − K).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 4N | Unsigned binary operand |
| res_o | output | N | Residue of x_i modulo 2^N − K |

## Verification
The width bound of each folding pass, the congruence it must keep, the single-subtraction bound of the final adder and the output range are checked whenever the input changes. Those checks are placed next to the adders they guard. Only the bench scenarios can show that the final value is the correct residue and not merely some value below the modulus. They can also show that corner inputs (zero, all-ones, exact multiples) come out right, and that the variant with the extra pass behaves for a parameter set that needs it.

// File: rtl/resconv_mk.sv
module resconv_mk #(
  parameter int N = 16,
  parameter int K = 3
) (
  input  logic [4*N-1:0] x_i,
  output logic [N-1:0]   res_o
);
  localparam int P  = $clog2(K);
  localparam longint unsigned MOD = (64'd1 << N) - 64'(K);
  localparam longint unsigned K2R = (64'(K) * 64'(K)) % MOD;
  localparam longint unsigned K3R = (64'(K) * 64'(K) * 64'(K)) % MOD;
  localparam bit  SKIP = (N >= 2*P + 1);
  localparam int  W1 = 2*N + 2;
  localparam int  W2 = N + P + 1;
  localparam int  W3 = N + 3;
  localparam int  WF = 2*N + 5;

  if (K < 3 || 2*P > N) begin : g_bad_params
    $error("resconv_mk: K must be >= 3 and ceil(log2 K) <= N/2");
  end

  logic [WF-1:0] s1f, s2f, tf, subf;
  logic [W1-1:0] s1;
  logic [W2-1:0] s2;

  assign s1f = WF'(K3R) * WF'(x_i[4*N-1:3*N])
             + WF'(K2R) * WF'(x_i[3*N-1:2*N])
             + WF'(K)   * WF'(x_i[2*N-1:N])
             + WF'(x_i[N-1:0]);
  assign s1 = s1f[W1-1:0];

  assign s2f = WF'(K2R) * WF'(s1[W1-1:2*N])
             + WF'(K)   * WF'(s1[2*N-1:N])
             + WF'(s1[N-1:0]);
  assign s2 = s2f[W2-1:0];

  if (SKIP) begin : g_short
    assign tf = WF'(K) * WF'(s2[W2-1:N]) + WF'(s2[N-1:0]);
  end else begin : g_long
    logic [WF-1:0] s3f;
    logic [W3-1:0] s3;
    assign s3f = WF'(K) * WF'(s2[W2-1:N]) + WF'(s2[N-1:0]);
    assign s3  = s3f[W3-1:0];
    assign tf  = WF'(K) * WF'(s3[W3-1:N]) + WF'(s3[N-1:0]);

    always_comb begin
      assert_s3_fit_R5: assert (s3f < (WF'(1) << W3))
        else $error("third pass overflow");
      assert_s3_congr_R5: assert ((s3f % MOD) == (s2f % MOD))
        else $error("third pass changed residue");
    end
  end

  assign subf  = tf - WF'(MOD);
  assign res_o = (tf >= WF'(MOD)) ? subf[N-1:0] : tf[N-1:0];

  always_comb begin
    assert_s1_fit_R3: assert (s1f < (WF'(1) << W1))
      else $error("first sum overflow");
    assert_s1_congr_R1: assert ((s1f % MOD) == (64'(x_i) % MOD))
      else $error("first sum changed residue");
    assert_s2_fit_R4: assert (s2f < (WF'(1) << W2))
      else $error("second pass overflow");
    assert_s2_congr_R4: assert ((s2f % MOD) == (s1f % MOD))
      else $error("second pass changed residue");
    assert_single_sub_R6: assert (tf < WF'(2 * MOD))
      else $error("modular adder input too large");
    assert_res_range_R2: assert (64'(res_o) < MOD)
      else $error("residue out of range");
  end
endmodule

// File: tb/tb_resconv_mk.sv
module tb_resconv_mk;
  localparam int N  = 16;
  localparam int K  = 3;
  localparam int N2 = 8;
  localparam int K2 = 11;
  localparam longint unsigned M1 = (64'd1 << N) - K;
  localparam longint unsigned M2 = (64'd1 << N2) - K2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4*N-1:0]  x;
  logic [N-1:0]    r;
  logic [4*N2-1:0] x2;
  logic [N2-1:0]   r2;

  resconv_mk #(.N(N),  .K(K))  dut  (.x_i(x),  .res_o(r));
  resconv_mk #(.N(N2), .K(K2)) dut2 (.x_i(x2), .res_o(r2));

  int n_chk = 0;
  int n_bad = 0;

  localparam int NV = 10;
  localparam logic [63:0] VEC [NV] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_FFFC, 64'h0000_0000_0000_FFFD,
    64'h0000_0000_0001_0000, 64'h0001_0000_0000_0000,
    64'h8000_0000_0000_0000, 64'hFFFF_0000_FFFF_0000,
    64'h0123_4567_89AB_CDEF, 64'hFFFE_FFFE_FFFE_FFFE
  };

  task automatic chk(string tag, longint unsigned got, longint unsigned exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run1(logic [63:0] v, string tag);
    @(posedge clk);
    x = v;
    @(negedge clk);
    chk(tag, 64'(r), v % M1);
    chk("R2", (64'(r) < M1) ? 1 : 0, 1);
  endtask

  task automatic run2(logic [31:0] v, string tag);
    @(posedge clk);
    x2 = v;
    @(negedge clk);
    chk(tag, 64'(r2), 64'(v) % M2);
  endtask

  initial begin
    #(5ns * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    x = '0;
    x2 = '0;
    @(negedge clk);
    chk("R7 zero", 64'(r), 0);

    for (int i = 0; i < NV; i++) run1(VEC[i], "R1 table");

    run1(64'hFFFF_FFFF_FFFF_FFFF, "R7 all-ones");
    run1(M1, "R7 multiple");
    run1(M1 * 64'd1234567, "R7 multiple");
    run1((64'hFFFF_FFFF_FFFF_FFFF / M1) * M1, "R7 largest multiple");
    run1((64'hFFFF_FFFF_FFFF_FFFF / M1) * M1 - 1, "R6 below multiple");
    run1(M1 - 1, "R6 modulus minus one");

    for (int i = 0; i < 2000; i++) run1({$urandom, $urandom}, "R1 random");
    for (int i = 0; i < 64; i++)  run1(64'd1 << i, "R3 power of two");

    run2(32'h0, "R5 zero");
    run2(32'hFFFF_FFFF, "R5 all-ones");
    run2(32'(M2 * 64'd12345), "R5 multiple");
    for (int i = 0; i < 2000; i++) run2($urandom, "R5 random");
    for (int i = 0; i < 32; i++)  run2(32'd1 << i, "R4 power of two");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule